// File: doc/BRIEF.md
# Burst-Coalescing Completion Descriptor Queue

This block gathers single-dword completion descriptors from an upstream producer into a small on-chip queue of eight entries. It then drains them into a circular descriptor ring in host memory as bursts, which cuts the number of separate bus transactions. Each burst starts with a start index and a length. The descriptor words then follow as valid/ready beats, in the order they were pushed.

With coalescing enabled, the block holds descriptors until the queue occupancy reaches a high-water mark of six. It then tries to empty the whole queue in one burst. With coalescing disabled, any waiting descriptor starts a burst as soon as the block is idle. Before each burst the block works out the free ring space from the host read pointer and its own write pointer, and it never writes more than fits. If nothing fits, it reports a write error and keeps the descriptors for a later attempt. The write pointer advances only when a burst completes.

Top module: `desc_burst_fifo`

## Requirements
- R1: Descriptor words leave on the beat interface in exactly the order they were pushed, across burst boundaries and with pushes arriving during a burst.
- R2: While `coalesce_en` is 1, no burst starts until the queue holds at least 6 descriptors; with 5 or fewer held, nothing is written.
- R3: A burst length (`burst_len`) equals the smaller of the queue occupancy and the free ring space, both taken at the moment the burst is decided.
- R4: Free ring space is (host_rd_ptr - wr_ptr - 1) modulo ring_size, so one ring slot always stays empty; host_rd_ptr must be below ring_size.
- R5: When a burst is due and the free space is 0, `wr_err` pulses high (once per attempt cycle), no beats are issued, `wr_ptr` does not move, and the descriptors stay queued and are sent once space appears.
- R6: When the last beat of a burst is accepted, `wr_ptr` becomes (start index + length) modulo ring_size on the next cycle, and `wr_done` is high for exactly that one cycle.
- R7: While `coalesce_en` is 0, a single queued descriptor starts a burst of length 1 without waiting for more.
- R8: A push that arrives while the queue holds 8 descriptors is dropped, and `push_ovf` is high in the following cycle; the 8 held descriptors are unaffected.
- R9: `burst_idx` equals the write pointer at burst start. Beat slot addresses run upward from it and wrap from ring_size-1 to 0.
- R10: While `beat_valid` is 1 and `beat_ready` is 0, the beat data is held stable and the burst does not progress.
- R11: After synchronous reset, the queue is empty, `wr_ptr` is 0 and `beat_valid`, `burst_start`, `wr_done`, `wr_err` and `push_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Descriptor push strobe |
| push_data | input | DATA_W | Descriptor word |
| coalesce_en | input | 1 | 1: wait for high-water mark; 0: forward at once |
| host_rd_ptr | input | PTR_W | Ring slot the host will read next |
| ring_size | input | PTR_W+1 | Number of ring slots (2 or more) |
| burst_start | output | 1 | One-cycle pulse with the first beat of a burst |
| burst_idx | output | PTR_W | Ring slot of the first beat |
| burst_len | output | CNT_W | Number of beats in the burst |
| beat_valid | output | 1 | Beat data valid |
| beat_data | output | DATA_W | Descriptor word of the current beat |
| beat_ready | input | 1 | Downstream accepts the beat |
| wr_ptr | output | PTR_W | Ring write pointer after the last finished burst |
| wr_done | output | 1 | One-cycle pulse after a burst completes |
| wr_err | output | 1 | Pulse when a burst was due but the ring was full |
| push_ovf | output | 1 | Pulse after a push was dropped on a full queue |

## Verification
Two events can land on the same clock edge: a new descriptor push and the pop of the head descriptor by an accepted beat. The queue must then keep the correct count and keep the pushed words in order. The bench causes this by streaming pushes back to back with coalescing off, so later pushes arrive while earlier bursts are still draining. It then checks that the collected beat words match the push order exactly and that the final write pointer equals the number of words pushed. A second overlap is a push while the queue is full and no room is left in the ring. In that case the push must be dropped, and the later burst must carry only the first eight words.

// File: rtl/desc_burst_pkg.sv
package desc_burst_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BEAT = 1'b1
  } burst_state_e;
endpackage

// File: rtl/desc_store.sv
module desc_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_idx, rd_idx;
  logic              do_wr, do_rd;

  assign full    = (count == CNT_W'(DEPTH));
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && (count != '0);
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_idx <= wr_idx + AW'(1);
      if (do_rd) rd_idx <= rd_idx + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  assert_full_push_keeps_count_R8: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/ring_space.sv
module ring_space #(
  parameter int PTR_W = 10
) (
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W:0]   size,
  output logic [PTR_W:0]   free
);
  logic [PTR_W+1:0] raw;

  always_comb begin
    raw = {2'b00, rd_ptr} + {1'b0, size} - {2'b00, wr_ptr} - (PTR_W+2)'(1);
    if (raw >= {1'b0, size}) raw = raw - {1'b0, size};
    free = raw[PTR_W:0];
  end
endmodule

// File: rtl/desc_burst_fifo.sv
module desc_burst_fifo
  import desc_burst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int HWM    = 6,
  parameter int PTR_W  = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              coalesce_en,
  input  logic [PTR_W-1:0]  host_rd_ptr,
  input  logic [PTR_W:0]    ring_size,
  output logic              burst_start,
  output logic [PTR_W-1:0]  burst_idx,
  output logic [CNT_W-1:0]  burst_len,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data,
  input  logic              beat_ready,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              wr_done,
  output logic              wr_err,
  output logic              push_ovf
);
  burst_state_e     state;
  logic [CNT_W-1:0] count;
  logic             full;
  logic [PTR_W:0]   free;
  logic [PTR_W-1:0] cursor;
  logic [PTR_W-1:0] cursor_nxt;
  logic [CNT_W-1:0] remaining;
  logic             beat_fire;
  logic             due;
  logic [CNT_W-1:0] take;

  assign beat_valid = (state == ST_BEAT);
  assign beat_fire  = beat_valid && beat_ready;

  desc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push_valid),
    .wr_data (push_data),
    .rd_en   (beat_fire),
    .rd_data (beat_data),
    .count   (count),
    .full    (full)
  );

  ring_space #(.PTR_W(PTR_W)) space_i (
    .rd_ptr (host_rd_ptr),
    .wr_ptr (wr_ptr),
    .size   (ring_size),
    .free   (free)
  );

  always_comb begin
    due = coalesce_en ? (count >= CNT_W'(HWM)) : (count != '0);
    if ({{(PTR_W+1-CNT_W){1'b0}}, count} <= free) take = count;
    else take = CNT_W'(free);
    if (({1'b0, cursor} + (PTR_W+1)'(1)) >= ring_size) cursor_nxt = '0;
    else cursor_nxt = cursor + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      wr_ptr      <= '0;
      cursor      <= '0;
      remaining   <= '0;
      burst_start <= 1'b0;
      burst_idx   <= '0;
      burst_len   <= '0;
      wr_done     <= 1'b0;
      wr_err      <= 1'b0;
      push_ovf    <= 1'b0;
    end else begin
      burst_start <= 1'b0;
      wr_done     <= 1'b0;
      wr_err      <= 1'b0;
      push_ovf    <= push_valid && full;
      case (state)
        ST_IDLE: begin
          if (due) begin
            if (free == '0) begin
              wr_err <= 1'b1;
            end else begin
              state       <= ST_BEAT;
              burst_start <= 1'b1;
              burst_idx   <= wr_ptr;
              burst_len   <= take;
              cursor      <= wr_ptr;
              remaining   <= take;
            end
          end
        end
        ST_BEAT: begin
          if (beat_ready) begin
            cursor    <= cursor_nxt;
            remaining <= remaining - CNT_W'(1);
            if (remaining == CNT_W'(1)) begin
              state   <= ST_IDLE;
              wr_ptr  <= cursor_nxt;
              wr_done <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_hwm_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (burst_start && $past(coalesce_en)) |-> ($past(count) >= CNT_W'(HWM)));

  assert_len_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    burst_start |-> (burst_len != '0 && burst_len <= CNT_W'(DEPTH)));

  assert_err_no_advance_R5: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> (!beat_valid && $stable(wr_ptr)));

  assert_done_moves_ptr_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_done && $past(burst_len) != '0) |-> !beat_valid);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_data)));

  assert_idx_in_ring_R9: assert property (@(posedge clk) disable iff (rst)
    burst_start |-> ({1'b0, burst_idx} < ring_size));
endmodule

// File: tb/desc_burst_fifo_tb_top.sv
module desc_burst_fifo_tb_top;
  localparam int DATA_W = 32;
  localparam int PTR_W  = 10;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              push_valid;
  logic [DATA_W-1:0] push_data;
  logic              coalesce_en;
  logic [PTR_W-1:0]  host_rd_ptr;
  logic [PTR_W:0]    ring_size;
  logic              burst_start;
  logic [PTR_W-1:0]  burst_idx;
  logic [CNT_W-1:0]  burst_len;
  logic              beat_valid;
  logic [DATA_W-1:0] beat_data;
  logic              beat_ready;
  logic [PTR_W-1:0]  wr_ptr;
  logic              wr_done;
  logic              wr_err;
  logic              push_ovf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int n_bursts, n_beats, n_errs, n_ovf, n_done;
  int first_len, first_idx;
  logic [DATA_W-1:0] beat_log [64];

  always #10 clk = ~clk;

  desc_burst_fifo dut_i (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .coalesce_en(coalesce_en), .host_rd_ptr(host_rd_ptr), .ring_size(ring_size),
    .burst_start(burst_start), .burst_idx(burst_idx), .burst_len(burst_len),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_ready(beat_ready),
    .wr_ptr(wr_ptr), .wr_done(wr_done), .wr_err(wr_err), .push_ovf(push_ovf)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (!rst) begin
      if (burst_start) begin
        if (n_bursts == 0) begin
          first_len = int'(burst_len);
          first_idx = int'(burst_idx);
        end
        n_bursts = n_bursts + 1;
      end
      if (beat_valid && beat_ready) begin
        if (n_beats < 64) beat_log[n_beats] = beat_data;
        n_beats = n_beats + 1;
      end
      if (wr_err) n_errs = n_errs + 1;
      if (push_ovf) n_ovf = n_ovf + 1;
      if (wr_done) n_done = n_done + 1;
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_bursts = 0; n_beats = 0; n_errs = 0; n_ovf = 0; n_done = 0;
    first_len = 0; first_idx = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1; push_valid = 1'b0; push_data = '0; beat_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    clear_log();
  endtask

  task automatic push_n(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      push_valid = 1'b1;
      push_data  = DATA_W'(base + i);
      @(posedge clk); #1;
    end
    push_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  localparam int NROW = 6;
  localparam int T_EN   [NROW] = '{1, 1, 1, 1, 0, 1};
  localparam int T_N    [NROW] = '{6, 5, 6, 6, 1, 6};
  localparam int T_RD   [NROW] = '{0, 0, 4, 1, 0, 0};
  localparam int T_SIZE [NROW] = '{16, 16, 16, 16, 16, 8};
  localparam int T_LEN  [NROW] = '{6, 0, 3, 0, 1, 6};
  localparam int T_ERR  [NROW] = '{0, 0, 0, 1, 0, 0};

  initial begin
    coalesce_en = 1'b1; host_rd_ptr = '0; ring_size = 11'd16;
    do_reset();
    // R11 reset state
    check("R11 beat_valid", int'(beat_valid), 0);
    check("R11 wr_ptr", int'(wr_ptr), 0);
    check("R11 flags", int'({burst_start, wr_done, wr_err, push_ovf}), 0);

    for (int r = 0; r < NROW; r++) begin
      coalesce_en = T_EN[r][0];
      host_rd_ptr = PTR_W'(T_RD[r]);
      ring_size   = (PTR_W+1)'(T_SIZE[r]);
      do_reset();
      push_n(T_N[r], 100 * r);
      idle(20);
      // R2 R3 R4 R7: burst length per row
      check($sformatf("R3 row %0d burst_len", r), (n_bursts > 0) ? first_len : 0, T_LEN[r]);
      check($sformatf("R5 row %0d err seen", r), int'(n_errs > 0), T_ERR[r]);
      check($sformatf("R6 row %0d wr_ptr", r), int'(wr_ptr), T_LEN[r]);
      if (T_LEN[r] > 0) begin
        check($sformatf("R6 row %0d done", r), n_done, 1);
        for (int i = 0; i < T_LEN[r]; i++)
          check($sformatf("R1 row %0d beat %0d", r, i), int'(beat_log[i]), 100 * r + i);
      end
    end

    // R5 retry after no-room condition
    coalesce_en = 1'b1; ring_size = 11'd16; host_rd_ptr = 10'd1;
    do_reset();
    push_n(6, 500);
    idle(5);
    check("R5 no beats while full", n_beats, 0);
    check("R5 wr_ptr held", int'(wr_ptr), 0);
    host_rd_ptr = 10'd8;
    idle(15);
    check("R5 retry len", first_len, 6);
    check("R5 retry data", int'(beat_log[5]), 505);

    // R8 overflow drop
    coalesce_en = 1'b1; ring_size = 11'd16; host_rd_ptr = 10'd1;
    do_reset();
    push_n(9, 700);
    idle(2);
    check("R8 ovf pulse", n_ovf, 1);
    host_rd_ptr = 10'd0;
    idle(20);
    check("R8 burst len 8", first_len, 8);
    check("R8 last kept", int'(beat_log[7]), 707);
    check("R8 total beats", n_beats, 8);

    // R9 wrap across ring end
    coalesce_en = 1'b1; ring_size = 11'd8; host_rd_ptr = 10'd0;
    do_reset();
    push_n(6, 800);
    idle(15);
    host_rd_ptr = 10'd6;
    clear_log();
    push_n(6, 900);
    idle(15);
    check("R9 start idx", first_idx, 6);
    check("R9 wrapped wr_ptr", int'(wr_ptr), 4);
    check("R9 wrap data", int'(beat_log[5]), 905);

    // R1 push during pop, coalescing off
    coalesce_en = 1'b0; ring_size = 11'd16; host_rd_ptr = 10'd0;
    do_reset();
    push_n(5, 300);
    idle(20);
    for (int i = 0; i < 5; i++)
      check($sformatf("R1 stream beat %0d", i), int'(beat_log[i]), 300 + i);
    check("R1 stream wr_ptr", int'(wr_ptr), 5);

    // R10 stall holds data
    coalesce_en = 1'b0; ring_size = 11'd16; host_rd_ptr = 10'd0;
    do_reset();
    beat_ready = 1'b0;
    push_n(1, 42);
    idle(4);
    check("R10 valid held", int'(beat_valid), 1);
    check("R10 data held", int'(beat_data), 42);
    check("R10 no done", n_done, 0);
    beat_ready = 1'b1;
    idle(3);
    check("R10 done after ready", n_done, 1);
    check("R10 wr_ptr", int'(wr_ptr), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule